// File: doc/BRIEF.md
# SCSI Controller Byte FIFO with Command Capture

This block sits behind the host-visible data register of a SCSI controller. Host writes land in a small byte FIFO, or, while command-capture mode is on, in a separate command buffer that collects the command bytes of a select sequence. Host reads pop the FIFO, except during the data-out bus phase, when a read returns zero and pops nothing.

The block also holds the FIFO-flags byte count, the interrupt code byte and the interrupt line. A status-load request puts a two-byte response (status byte, then a zero message byte) into the FIFO and raises the interrupt. A flush request reports function-complete. A select-start request empties the FIFO before a select command reads its command bytes from it. Pointers return to zero whenever a read drains the FIFO. Full is reported when the write pointer reaches the last entry, so at most DEPTH-1 bytes are stored.

All outputs are registered, except `cmd_rd_byte`, which is a combinational read of the command buffer. Each request acts on a rising clock edge, and its result is visible after that edge.

Top module: `scsi_xfer_fifo`

## Requirements
- R1: After synchronous reset, byte_count, fifo_flags, intr_code, cmd_len and rd_data are 0, and irq, overrun and fifo_full are 0.
- R2: A write with capture_en low stores wr_data and increments byte_count. fifo_full is 1 exactly when the write pointer equals FIFO_DEPTH-1. A write while fifo_full is 1 is dropped, and byte_count is unchanged.
- R3: A read while phase equals 3'b000 (data-out) sets rd_data to 0 and leaves byte_count unchanged.
- R4: A read in any other phase returns the bytes in write order and decrements byte_count. A read with byte_count 0 leaves rd_data and byte_count unchanged.
- R5: When a read leaves the read and write pointers equal, both return to 0, so FIFO_DEPTH-1 further writes are accepted.
- R6: A write with capture_en high stores wr_data into the command buffer at index cmd_len and increments cmd_len, leaving the FIFO untouched. When cmd_len equals CMD_DEPTH, the byte is dropped. cmd_rd_byte shows the entry at cmd_rd_idx.
- R7: cmd_take sets cmd_len to 0. A capture write in the same cycle is discarded without an overrun.
- R8: sts_load makes the next two FIFO reads return sts_byte and then 8'h00. It sets byte_count to 2 and fifo_flags to 2, and sets irq to 1.
- R9: flush_cmd sets intr_code to 8'h08 (function complete) and fifo_flags to 0, and leaves the FIFO contents and byte_count unchanged.
- R10: sel_start sets byte_count to 0 and empties the FIFO.
- R11: irq_ack clears irq and intr_code, unless sts_load sets irq or flush_cmd sets intr_code in the same cycle.
- R12: Only one of sts_load, flush_cmd, sel_start, wr_en and rd_en acts per cycle, in that priority order, highest first. irq_ack and cmd_take act alongside them.
- R13: overrun is a one-cycle pulse in the cycle after a dropped write (FIFO or command buffer), and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write to the data register |
| wr_data | input | 8 | Byte written |
| rd_en | input | 1 | Host read of the data register |
| rd_data | output | 8 | Last byte read |
| phase | input | 3 | Bus phase; 3'b000 is data-out |
| capture_en | input | 1 | Command-capture mode active |
| cmd_take | input | 1 | Command consumed; clears the length |
| cmd_rd_idx | input | $clog2(CMD_DEPTH) | Command buffer read index |
| cmd_rd_byte | output | 8 | Command buffer entry at cmd_rd_idx |
| sts_load | input | 1 | Load the status/message response |
| sts_byte | input | 8 | Status byte to load |
| flush_cmd | input | 1 | Flush command |
| sel_start | input | 1 | Select command start; empties the FIFO |
| irq_ack | input | 1 | Interrupt acknowledge |
| byte_count | output | $clog2(FIFO_DEPTH+1) | Bytes held in the FIFO |
| fifo_full | output | 1 | Write pointer at the last entry |
| fifo_flags | output | $clog2(FIFO_DEPTH+1) | FIFO-flags count register |
| intr_code | output | 8 | Interrupt code byte |
| irq | output | 1 | Interrupt line |
| overrun | output | 1 | Dropped-write pulse |
| cmd_len | output | $clog2(CMD_DEPTH+1) | Command bytes captured |

## Verification
The assertions assume that reset is held for at least one edge before any request, and that requests are sampled only at rising edges. They also assume that combinations of requests follow the priority of R12 and are not mutually excluded by the environment. The stimulus drives every input on the falling edge and deliberately asserts several requests together, so the priority path is exercised rather than assumed away. Random phases include the data-out code often enough that no-pop reads occur alongside ordinary pops.

// File: rtl/sxf_pkg.sv
package sxf_pkg;
    localparam int BYTE_W        = 8;
    localparam int DEF_FIFO_DEPTH = 16;
    localparam int DEF_CMD_DEPTH  = 32;
    localparam logic [2:0]        PHASE_DOUT = 3'b000;
    localparam logic [BYTE_W-1:0] INTR_FC    = 8'h08;
    localparam int                STS_PAIR   = 2;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_STATUS,
        OP_FLUSH,
        OP_SELECT,
        OP_WRITE_FIFO,
        OP_WRITE_CMD,
        OP_READ
    } op_e;

    function automatic logic is_data_out(input logic [2:0] ph);
        return ph == PHASE_DOUT;
    endfunction
endpackage

// File: rtl/sxf_op_decode.sv
module sxf_op_decode
    import sxf_pkg::*;
(
    input  logic sts_load,
    input  logic flush_cmd,
    input  logic sel_start,
    input  logic wr_en,
    input  logic rd_en,
    input  logic capture_en,
    input  logic cmd_take,
    output op_e  op
);
    always_comb begin
        op = OP_IDLE;
        if (sts_load)       op = OP_STATUS;
        else if (flush_cmd) op = OP_FLUSH;
        else if (sel_start) op = OP_SELECT;
        else if (wr_en) begin
            if (!capture_en)   op = OP_WRITE_FIFO;
            else if (!cmd_take) op = OP_WRITE_CMD;
            else               op = OP_IDLE;
        end
        else if (rd_en)     op = OP_READ;
    end
endmodule

// File: rtl/sxf_fifo_store.sv
module sxf_fifo_store
    import sxf_pkg::*;
#(
    parameter int DEPTH = DEF_FIFO_DEPTH
) (
    input  logic                       clk,
    input  logic                       rst,
    input  op_e                        op,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [BYTE_W-1:0]          sts_byte,
    input  logic [2:0]                 phase,
    output logic [BYTE_W-1:0]          rd_data,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       drop
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PW-1:0]     rp, wp;
    logic [PW-1:0]     rp_inc;
    logic              has_data;
    logic              dout;

    assign full     = (wp == PW'(DEPTH-1));
    assign drop     = (op == OP_WRITE_FIFO) && full;
    assign rp_inc   = rp + PW'(1);
    assign has_data = (rp < wp);
    assign dout     = is_data_out(phase);

    // storage array, no reset
    always_ff @(posedge clk) begin
        if (op == OP_STATUS) begin
            mem[0] <= sts_byte;
            mem[1] <= '0;
        end else if (op == OP_WRITE_FIFO && !full) begin
            mem[wp] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rp      <= '0;
            wp      <= '0;
            count   <= '0;
            rd_data <= '0;
        end else begin
            case (op)
                OP_STATUS: begin
                    rp    <= '0;
                    wp    <= PW'(STS_PAIR);
                    count <= CW'(STS_PAIR);
                end
                OP_SELECT: begin
                    rp    <= '0;
                    wp    <= '0;
                    count <= '0;
                end
                OP_WRITE_FIFO: begin
                    if (!full) begin
                        wp    <= wp + PW'(1);
                        count <= count + CW'(1);
                    end
                end
                OP_READ: begin
                    if (dout) begin
                        rd_data <= '0;
                        if (rp == wp) begin
                            rp <= '0;
                            wp <= '0;
                        end
                    end else if (has_data) begin
                        rd_data <= mem[rp];
                        count   <= count - CW'(1);
                        if (rp_inc == wp) begin
                            rp <= '0;
                            wp <= '0;
                        end else begin
                            rp <= rp_inc;
                        end
                    end else begin
                        rp <= '0;
                        wp <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH-1));
    p_drop_hold_r2: assert property (@(posedge clk) disable iff (rst)
        drop |=> $stable(count));
    p_dout_no_pop_r3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_READ && dout) |=> (rd_data == '0 && $stable(count)));
    p_status_len_r8: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STATUS) |=> (count == CW'(STS_PAIR) && !full));
    p_select_empty_r10: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SELECT) |=> (count == '0));
endmodule

// File: rtl/sxf_cmd_capture.sv
module sxf_cmd_capture
    import sxf_pkg::*;
#(
    parameter int DEPTH = DEF_CMD_DEPTH
) (
    input  logic                       clk,
    input  logic                       rst,
    input  op_e                        op,
    input  logic                       take,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [$clog2(DEPTH)-1:0]   rd_idx,
    output logic [BYTE_W-1:0]          rd_byte,
    output logic [$clog2(DEPTH+1)-1:0] len,
    output logic                       drop
);
    localparam int LW = $clog2(DEPTH+1);
    localparam int IW = $clog2(DEPTH);

    logic [BYTE_W-1:0] cbuf [DEPTH];
    logic              room;
    logic              store;

    assign room    = (len < LW'(DEPTH));
    assign store   = (op == OP_WRITE_CMD) && room;
    assign drop    = (op == OP_WRITE_CMD) && !room;
    assign rd_byte = cbuf[rd_idx];

    always_ff @(posedge clk) begin
        if (store) cbuf[len[IW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)        len <= '0;
        else if (take)  len <= '0;
        else if (store) len <= len + LW'(1);
    end

    p_cmd_bound_r6: assert property (@(posedge clk) disable iff (rst)
        len <= LW'(DEPTH));
    p_cmd_drop_r6: assert property (@(posedge clk) disable iff (rst)
        drop |=> $stable(len));
    p_take_clears_r7: assert property (@(posedge clk) disable iff (rst)
        take |=> (len == '0));
endmodule

// File: rtl/sxf_status_regs.sv
module sxf_status_regs
    import sxf_pkg::*;
#(
    parameter int FW = $clog2(DEF_FIFO_DEPTH+1)
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic              irq_ack,
    input  logic              drop_any,
    output logic [FW-1:0]     flags,
    output logic [BYTE_W-1:0] intr,
    output logic              irq,
    output logic              overrun
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            intr    <= '0;
            irq     <= 1'b0;
            overrun <= 1'b0;
        end else begin
            overrun <= drop_any;
            if (irq_ack) begin
                irq  <= 1'b0;
                intr <= '0;
            end
            case (op)
                OP_STATUS: begin
                    flags <= FW'(STS_PAIR);
                    irq   <= 1'b1;
                end
                OP_FLUSH: begin
                    intr  <= INTR_FC;
                    flags <= '0;
                end
                default: ;
            endcase
        end
    end

    p_flush_r9: assert property (@(posedge clk) disable iff (rst)
        (op == OP_FLUSH) |=> (intr == INTR_FC && flags == '0));
    p_status_irq_r8: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STATUS) |=> (irq && flags == FW'(STS_PAIR)));
    p_ack_r11: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && op != OP_STATUS) |=> !irq);
endmodule

// File: rtl/scsi_xfer_fifo.sv
module scsi_xfer_fifo
    import sxf_pkg::*;
#(
    parameter int FIFO_DEPTH = DEF_FIFO_DEPTH,
    parameter int CMD_DEPTH  = DEF_CMD_DEPTH
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [7:0]                       wr_data,
    input  logic                             rd_en,
    output logic [7:0]                       rd_data,
    input  logic [2:0]                       phase,
    input  logic                             capture_en,
    input  logic                             cmd_take,
    input  logic [$clog2(CMD_DEPTH)-1:0]     cmd_rd_idx,
    output logic [7:0]                       cmd_rd_byte,
    input  logic                             sts_load,
    input  logic [7:0]                       sts_byte,
    input  logic                             flush_cmd,
    input  logic                             sel_start,
    input  logic                             irq_ack,
    output logic [$clog2(FIFO_DEPTH+1)-1:0]  byte_count,
    output logic                             fifo_full,
    output logic [$clog2(FIFO_DEPTH+1)-1:0]  fifo_flags,
    output logic [7:0]                       intr_code,
    output logic                             irq,
    output logic                             overrun,
    output logic [$clog2(CMD_DEPTH+1)-1:0]   cmd_len
);
    localparam int FW = $clog2(FIFO_DEPTH+1);

    op_e  op;
    logic fifo_drop;
    logic cmd_drop;

    sxf_op_decode u_dec (
        .sts_load   (sts_load),
        .flush_cmd  (flush_cmd),
        .sel_start  (sel_start),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .capture_en (capture_en),
        .cmd_take   (cmd_take),
        .op         (op)
    );

    sxf_fifo_store #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .wr_data  (wr_data),
        .sts_byte (sts_byte),
        .phase    (phase),
        .rd_data  (rd_data),
        .count    (byte_count),
        .full     (fifo_full),
        .drop     (fifo_drop)
    );

    sxf_cmd_capture #(.DEPTH(CMD_DEPTH)) u_cmd (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .take    (cmd_take),
        .wr_data (wr_data),
        .rd_idx  (cmd_rd_idx),
        .rd_byte (cmd_rd_byte),
        .len     (cmd_len),
        .drop    (cmd_drop)
    );

    sxf_status_regs #(.FW(FW)) u_sts (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .irq_ack  (irq_ack),
        .drop_any (fifo_drop | cmd_drop),
        .flags    (fifo_flags),
        .intr     (intr_code),
        .irq      (irq),
        .overrun  (overrun)
    );

    p_ovr_cause_r13: assert property (@(posedge clk) disable iff (rst)
        overrun |-> $past(wr_en));
    p_read_loses_r12: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en && !sts_load && !flush_cmd && !sel_start) |=> $stable(rd_data));
endmodule

// File: tb/scsi_xfer_fifo_tb.sv
module scsi_xfer_fifo_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FD = 16;
    localparam int CD = 32;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en, rd_en, capture_en, cmd_take, sts_load, flush_cmd, sel_start, irq_ack;
    logic [7:0] wr_data, sts_byte, rd_data, cmd_rd_byte, intr_code;
    logic [2:0] phase;
    logic [4:0] cmd_rd_idx;
    logic [4:0] byte_count, fifo_flags;
    logic [5:0] cmd_len;
    logic       fifo_full, irq, overrun;

    scsi_xfer_fifo #(.FIFO_DEPTH(FD), .CMD_DEPTH(CD)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .phase(phase), .capture_en(capture_en), .cmd_take(cmd_take),
        .cmd_rd_idx(cmd_rd_idx), .cmd_rd_byte(cmd_rd_byte), .sts_load(sts_load),
        .sts_byte(sts_byte), .flush_cmd(flush_cmd), .sel_start(sel_start),
        .irq_ack(irq_ack), .byte_count(byte_count), .fifo_full(fifo_full),
        .fifo_flags(fifo_flags), .intr_code(intr_code), .irq(irq),
        .overrun(overrun), .cmd_len(cmd_len)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    // expected-state model built from the requirements
    int m_mem [FD];
    int m_cmd [CD];
    int m_rp, m_wp, m_cnt, m_clen, m_flags, m_intr, m_irq, m_rd, m_ovr;
    string cur_req;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void model_reset();
        m_rp = 0; m_wp = 0; m_cnt = 0; m_clen = 0; m_flags = 0;
        m_intr = 0; m_irq = 0; m_rd = 0; m_ovr = 0;
    endfunction

    function automatic void model_step(input bit s, input bit f, input bit sl, input bit w,
                                       input bit r, input bit cap, input bit tk, input bit ack,
                                       input int d, input int sb, input int ph);
        int nreq = int'(s) + int'(f) + int'(sl) + int'(w) + int'(r);
        m_ovr = 0;
        cur_req = "R12";
        if (ack) begin m_irq = 0; m_intr = 0; if (nreq == 0) cur_req = "R11"; end
        if (tk) begin m_clen = 0; if (nreq == 0) cur_req = "R7"; end
        if (s) begin
            m_mem[0] = sb; m_mem[1] = 0; m_cnt = 2; m_rp = 0; m_wp = 2;
            m_flags = 2; m_irq = 1; if (nreq == 1) cur_req = "R8";
        end else if (f) begin
            m_intr = 8; m_flags = 0; if (nreq == 1) cur_req = "R9";
        end else if (sl) begin
            m_cnt = 0; m_rp = 0; m_wp = 0; if (nreq == 1) cur_req = "R10";
        end else if (w) begin
            if (cap) begin
                if (!tk) begin
                    if (m_clen < CD) begin m_cmd[m_clen] = d; m_clen++; end
                    else m_ovr = 1;
                end
                if (nreq == 1) cur_req = tk ? "R7" : "R6";
            end else begin
                if (m_wp == FD-1) m_ovr = 1;
                else begin m_mem[m_wp] = d; m_wp++; m_cnt++; end
                if (nreq == 1) cur_req = "R2";
            end
        end else if (r) begin
            if (ph == 0) begin
                m_rd = 0; if (nreq == 1) cur_req = "R3";
            end else begin
                if (m_rp < m_wp) begin m_rd = m_mem[m_rp]; m_rp++; m_cnt--; end
                if (nreq == 1) cur_req = "R4";
            end
            if (m_rp == m_wp) begin m_rp = 0; m_wp = 0; if (nreq == 1 && ph != 0) cur_req = "R5"; end
        end
    endfunction

    task automatic compare_all(input string req);
        chk(req, "rd_data", int'(rd_data), m_rd);
        chk(req, "byte_count", int'(byte_count), m_cnt);
        chk(req, "fifo_full", int'(fifo_full), int'(m_wp == FD-1));
        chk(req, "fifo_flags", int'(fifo_flags), m_flags);
        chk(req, "intr_code", int'(intr_code), m_intr);
        chk(req, "irq", int'(irq), m_irq);
        chk("R13", "overrun", int'(overrun), m_ovr);
        chk(req, "cmd_len", int'(cmd_len), m_clen);
        if (int'(cmd_rd_idx) < m_clen)
            chk("R6", "cmd_rd_byte", int'(cmd_rd_byte), m_cmd[cmd_rd_idx]);
    endtask

    task automatic step(input bit s, input bit f, input bit sl, input bit w, input bit r,
                        input bit cap, input bit tk, input bit ack,
                        input int d, input int sb, input int ph, input int idx);
        sts_load = s; flush_cmd = f; sel_start = sl; wr_en = w; rd_en = r;
        capture_en = cap; cmd_take = tk; irq_ack = ack;
        wr_data = d[7:0]; sts_byte = sb[7:0]; phase = ph[2:0]; cmd_rd_idx = idx[4:0];
        @(posedge clk);
        model_step(s, f, sl, w, r, cap, tk, ack, d, sb, ph);
        @(negedge clk);
        compare_all(cur_req);
    endtask

    task automatic wr_byte(input int d);
        step(0, 0, 0, 1, 0, 0, 0, 0, d, 0, 1, 0);
    endtask
    task automatic rd_byte(input int ph);
        step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, ph, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1;
        sts_load = 0; flush_cmd = 0; sel_start = 0; wr_en = 0; rd_en = 0;
        capture_en = 0; cmd_take = 0; irq_ack = 0; wr_data = 0; sts_byte = 0;
        phase = 3'b001; cmd_rd_idx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        compare_all("R1");

        // R2: fill to the early-full point, then one dropped write (R13 pulse)
        for (int i = 0; i < FD-1; i++) wr_byte(8'h10 + i);
        chk("R2", "full after DEPTH-1 writes", int'(fifo_full), 1);
        wr_byte(8'hEE);
        chk("R13", "overrun after drop", int'(overrun), 1);
        rd_byte(3'b000);  // R3: data-out read returns 0, no pop
        chk("R3", "dout read data", int'(rd_data), 0);
        for (int i = 0; i < FD-1; i++) rd_byte(3'b011);  // R4 order, R5 drain
        chk("R4", "last byte", int'(rd_data), 8'h10 + FD - 2);
        rd_byte(3'b011);  // R4 empty read holds
        chk("R4", "empty read hold", int'(rd_data), 8'h10 + FD - 2);
        for (int i = 0; i < FD-1; i++) wr_byte(8'hA0 + i);  // R5 pointers reset
        chk("R5", "refill count", int'(byte_count), FD-1);

        // R10 select start empties the FIFO
        step(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        chk("R10", "count after select", int'(byte_count), 0);

        // R6 capture to full and beyond, R7 take
        for (int i = 0; i < CD+1; i++) step(0, 0, 0, 1, 0, 1, 0, 0, 8'h40 + i, 0, 1, i % CD);
        chk("R6", "cmd_len full", int'(cmd_len), CD);
        step(0, 0, 0, 1, 0, 1, 1, 0, 8'h99, 0, 1, 0);
        chk("R7", "cmd_len after take", int'(cmd_len), 0);

        // R8 status pair, R9 flush, R11 ack
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 8'h02, 1, 0);
        rd_byte(3'b111);
        chk("R8", "status byte", int'(rd_data), 8'h02);
        rd_byte(3'b111);
        chk("R8", "message byte", int'(rd_data), 0);
        step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        chk("R9", "intr code", int'(intr_code), 8'h08);
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0);
        chk("R11", "irq after ack", int'(irq), 0);

        // R12 priority combinations
        wr_byte(8'h55);
        step(0, 1, 1, 1, 1, 0, 0, 0, 8'h66, 0, 1, 0);
        chk("R12", "flush beats others", int'(byte_count), 1);
        step(0, 0, 0, 1, 1, 0, 0, 0, 8'h77, 0, 1, 0);
        chk("R12", "write beats read", int'(byte_count), 2);
        step(1, 1, 0, 0, 0, 0, 0, 1, 0, 8'h0C, 1, 0);
        chk("R12", "status beats flush", int'(intr_code), 0);

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            step($urandom_range(0, 49) == 0, $urandom_range(0, 39) == 0,
                 $urandom_range(0, 39) == 0, $urandom_range(0, 1) == 1,
                 $urandom_range(0, 1) == 1, $urandom_range(0, 5) == 0,
                 $urandom_range(0, 29) == 0, $urandom_range(0, 9) == 0,
                 int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                 int'($urandom_range(0, 7)), int'($urandom_range(0, CD-1)));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule